// File: doc/BRIEF.md
# Shifted Bit-Array Triplet Finder

This block finds three-plane coincidences among hit coordinates that arrive in any order from three detector planes: two outer planes (called A and C) and a centre plane (B). A straight track through the planes satisfies a + c = 2·b. The block keeps one occupancy bit per coordinate bin for each outer plane; the C pattern is held in mirrored bin order, so the pairing condition turns into a plain offset between the two patterns. For each centre hit, one logarithmic barrel shifter slides the mirrored C pattern into line with the A pattern. A single bank of AND gates then compares them at every allowed offset inside a tolerance window, and the resulting match map is drained one triplet at a time.

An event has three steps. A clear pulse empties both patterns and returns the block to fill mode. The outer-plane hits are streamed in, one per cycle. A start pulse switches to match mode, and centre-plane hits are streamed in. Every triplet found for a centre hit leaves on a valid/ready output stream before the next centre hit is taken. The input stream is back-pressured by `hit_ready`: a hit moves only in a cycle where `hit_valid` and `hit_ready` are both high. The output stream holds a triplet until `trip_ready` is sampled high with `trip_valid`.

Top module: `tf_triplet_finder`

## Requirements
- R1: After reset, `trip_valid` is 0, `hit_ready` is 1, the block is in fill mode, and both bin patterns are empty.
- R2: In fill mode, an accepted hit with plane code 0 (plane A) or 2 (plane C) sets the bin at its coordinate, at one hit per cycle. An accepted hit with plane code 1 (centre) or 3 is ignored and produces no output.
- R3: A `start` pulse enters match mode. In match mode, an accepted hit with plane code 0, 2 or 3 has no effect on the patterns.
- R4: For an accepted centre hit b, the block emits exactly the pairs (a, c), with bin a set in A and bin c set in C, for which |a + c − 2b| ≤ WIN (default 1). Each pair is emitted once, with `trip_b` = b.
- R5: The triplets for one centre hit are emitted in ascending order of a, and for equal a in ascending order of c. One triplet leaves per output handshake.
- R6: While `trip_valid` is high and `trip_ready` is low, `trip_valid`, `trip_a`, `trip_c` and `trip_b` stay unchanged.
- R7: `hit_ready` is low while any triplet is still pending. A centre hit with no match produces no output, and `hit_ready` is high again in the next cycle.
- R8: The first triplet for a centre hit is valid in the cycle right after the clock edge that accepts that hit.
- R9: `clear` empties both patterns, drops pending triplets (so `trip_valid` is 0 in the next cycle), returns to fill mode, and takes priority over a `start` in the same cycle. `hit_ready` is low while `clear` is high.
- R10: Pairs that use the edge bins 0 and N−1 are found. Candidate C bins outside 0..N−1 never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Empty patterns and pending triplets, return to fill mode |
| start | input | 1 | Enter match mode |
| hit_valid | input | 1 | Input hit valid |
| hit_ready | output | 1 | Input hit accepted this cycle when high with valid |
| hit_plane | input | 2 | Plane code: 0 = A, 1 = centre B, 2 = C, 3 = unused |
| hit_coord | input | CW | Hit bin coordinate |
| trip_valid | output | 1 | Triplet available |
| trip_ready | input | 1 | Consumer takes the triplet |
| trip_a | output | CW | Plane A bin of the triplet |
| trip_c | output | CW | Plane C bin of the triplet |
| trip_b | output | CW | Centre hit coordinate of the triplet |

## Verification
Single-track events with exact alignment, an off-by-one sum, and an off-by-two sum tell a correct tolerance window apart from one that is too narrow or too wide. Events in which several A and C bins meet one centre hit, including the edge bins 0 and 63, separate a correct emission order and mirrored indexing from a swapped or offset one. Random dense events with several centre hits each are compared against a brute-force loop over all (a, c) pairs, which exposes errors in the shifter stages that directed cases may not reach. Hits sent to the wrong phase, clear pulses during pending output, clear together with start, and a stalled consumer check that mode control and back-pressure leave the stored patterns and the output stream intact.

// File: rtl/tf_pkg.sv
package tf_pkg;
  typedef enum logic [1:0] {
    PL_A = 2'd0,
    PL_B = 2'd1,
    PL_C = 2'd2,
    PL_X = 2'd3
  } plane_e;
endpackage

// File: rtl/tf_bitarray.sv
// Occupancy bit per coordinate bin; optionally stored mirrored.
module tf_bitarray #(
  parameter int CW      = 6,
  parameter bit MIRROR  = 1'b0,
  localparam int N      = 1 << CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_coord,
  output logic [N-1:0]  bits
);
  logic [N-1:0] onehot;
  logic [N-1:0] set_vec;

  always_comb begin
    onehot = '0;
    onehot[wr_coord] = 1'b1;
  end

  generate
    if (MIRROR) begin : g_mirror
      always_comb set_vec = {<<{onehot}};
    end else begin : g_plain
      always_comb set_vec = onehot;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      bits <= '0;
    else if (clr)    bits <= '0;
    else if (wr_en)  bits <= bits | set_vec;
  end
endmodule

// File: rtl/tf_shifter.sv
// Logarithmic right barrel shifter, one stage per amount bit.
module tf_shifter #(
  parameter int IW = 200,
  parameter int SW = 7,
  parameter int OW = 66
) (
  input  logic [IW-1:0] din,
  input  logic [SW-1:0] amt,
  output logic [OW-1:0] dout
);
  logic [IW-1:0] stg [SW+1];

  assign stg[0] = din;
  generate
    for (genvar s = 0; s < SW; s++) begin : g_stage
      assign stg[s+1] = amt[s] ? (stg[s] >> (1 << s)) : stg[s];
    end
  endgenerate
  assign dout = stg[SW][OW-1:0];
endmodule

// File: rtl/tf_coinc.sv
// The single shared bank of coincidence gates over the tolerance window.
module tf_coinc #(
  parameter int CW  = 6,
  parameter int WIN = 1,
  localparam int N  = 1 << CW,
  localparam int K  = 2 * WIN + 1,
  localparam int QW = N + 2 * WIN
) (
  input  logic [N-1:0]   a_bits,
  input  logic [QW-1:0]  c_aligned,
  output logic [N*K-1:0] match_map
);
  // map bit a*K+k pairs A bin a with C bin 2b - a + (k - WIN)
  generate
    for (genvar a = 0; a < N; a++) begin : g_bin
      for (genvar k = 0; k < K; k++) begin : g_off
        assign match_map[a*K+k] = a_bits[a] & c_aligned[a + 2*WIN - k];
      end
    end
  endgenerate
endmodule

// File: rtl/tf_emit.sv
// Holds the match map of one centre hit and drains it lowest index first.
module tf_emit #(
  parameter int CW  = 6,
  parameter int WIN = 1,
  localparam int N  = 1 << CW,
  localparam int K  = 2 * WIN + 1,
  localparam int MW = N * K,
  localparam int IW = $clog2(MW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [MW-1:0] load_map,
  input  logic [CW-1:0] load_b,
  input  logic          pop,
  output logic          busy,
  output logic [CW-1:0] out_a,
  output logic [CW-1:0] out_c,
  output logic [CW-1:0] out_b
);
  logic [MW-1:0] pend;
  logic [CW-1:0] b_q;
  logic [IW-1:0] sel;

  always_comb begin
    int cv;
    sel   = '0;
    out_a = '0;
    cv    = 0;
    for (int a = N - 1; a >= 0; a--) begin
      for (int k = K - 1; k >= 0; k--) begin
        if (pend[a*K+k]) begin
          sel   = IW'(a * K + k);
          out_a = CW'(a);
          cv    = 2 * int'(b_q) - a + k - WIN;
        end
      end
    end
    out_c = CW'(cv);
  end

  assign busy  = |pend;
  assign out_b = b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      b_q  <= '0;
    end else if (clr) begin
      pend <= '0;
    end else if (load) begin
      pend <= load_map;
      b_q  <= load_b;
    end else if (pop) begin
      pend[sel] <= 1'b0;
    end
  end
endmodule

// File: rtl/tf_triplet_finder.sv
module tf_triplet_finder #(
  parameter int CW  = 6,
  parameter int WIN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          start,
  input  logic          hit_valid,
  output logic          hit_ready,
  input  logic [1:0]    hit_plane,
  input  logic [CW-1:0] hit_coord,
  output logic          trip_valid,
  input  logic          trip_ready,
  output logic [CW-1:0] trip_a,
  output logic [CW-1:0] trip_c,
  output logic [CW-1:0] trip_b
);
  import tf_pkg::*;

  localparam int N   = 1 << CW;
  localparam int K   = 2 * WIN + 1;
  localparam int QW  = N + 2 * WIN;
  localparam int OFF = N + WIN;
  localparam int PW  = 3 * N + 2 * WIN;
  localparam int SHW = CW + 1;

  logic          match_q;
  logic          busy;
  logic          acc;
  logic          wr_a, wr_c, load;
  logic [N-1:0]  a_bits, c_mirror;
  logic [PW-1:0] padded;
  logic [SHW-1:0] amt;
  logic [QW-1:0] c_aligned;
  logic [N*K-1:0] match_map;
  plane_e        plane;

  assign plane     = plane_e'(hit_plane);
  assign hit_ready = !clear && !(match_q && busy);
  assign acc       = hit_valid && hit_ready;
  assign wr_a      = acc && !match_q && (plane == PL_A);
  assign wr_c      = acc && !match_q && (plane == PL_C);
  assign load      = acc &&  match_q && (plane == PL_B);

  always_ff @(posedge clk) begin
    if (!rst_n)      match_q <= 1'b0;
    else if (clear)  match_q <= 1'b0;
    else if (start)  match_q <= 1'b1;
  end

  tf_bitarray #(.CW(CW), .MIRROR(1'b0)) u_arr_a (
    .clk(clk), .rst_n(rst_n), .clr(clear),
    .wr_en(wr_a), .wr_coord(hit_coord), .bits(a_bits)
  );

  tf_bitarray #(.CW(CW), .MIRROR(1'b1)) u_arr_c (
    .clk(clk), .rst_n(rst_n), .clr(clear),
    .wr_en(wr_c), .wr_coord(hit_coord), .bits(c_mirror)
  );

  // Mirrored C pattern placed in a zero-padded field so that shifting
  // by 2N-1-2b lines bin 2b-a of C up with bin a of A.
  always_comb begin
    padded = '0;
    padded[OFF +: N] = c_mirror;
  end
  assign amt = SHW'(2 * N - 1) - {hit_coord, 1'b0};

  tf_shifter #(.IW(PW), .SW(SHW), .OW(QW)) u_shift (
    .din(padded), .amt(amt), .dout(c_aligned)
  );

  tf_coinc #(.CW(CW), .WIN(WIN)) u_coinc (
    .a_bits(a_bits), .c_aligned(c_aligned), .match_map(match_map)
  );

  tf_emit #(.CW(CW), .WIN(WIN)) u_emit (
    .clk(clk), .rst_n(rst_n), .clr(clear),
    .load(load), .load_map(match_map), .load_b(hit_coord),
    .pop(trip_valid && trip_ready), .busy(busy),
    .out_a(trip_a), .out_c(trip_c), .out_b(trip_b)
  );

  assign trip_valid = busy;
endmodule

// File: rtl/tf_triplet_finder_chk.sv
module tf_triplet_finder_chk #(
  parameter int CW  = 6,
  parameter int WIN = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          hit_valid,
  input logic          hit_ready,
  input logic [1:0]    hit_plane,
  input logic          trip_valid,
  input logic          trip_ready,
  input logic [CW-1:0] trip_a,
  input logic [CW-1:0] trip_c,
  input logic [CW-1:0] trip_b
);
  int diff;
  assign diff = int'(trip_a) + int'(trip_c) - 2 * int'(trip_b);

  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    trip_valid |-> (diff <= WIN && diff >= -WIN));

  a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_valid && trip_ready && !clear) |=>
      (!trip_valid || ({trip_a, trip_c} > $past({trip_a, trip_c}))));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_valid && !trip_ready && !clear) |=>
      (trip_valid && $stable(trip_a) && $stable(trip_c) && $stable(trip_b)));

  a_r7_block: assert property (@(posedge clk) disable iff (!rst_n)
    trip_valid |-> !hit_ready);

  a_r8_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_valid) |-> $past(hit_valid && hit_ready && hit_plane == 2'd1));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !trip_valid);

  a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !hit_ready);
endmodule

bind tf_triplet_finder tf_triplet_finder_chk #(.CW(CW), .WIN(WIN)) u_chk (.*);

// File: tb/tb_tf_triplet_finder.sv
module tb_tf_triplet_finder;
  localparam int CW  = 6;
  localparam int WIN = 1;
  localparam int N   = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, start = 1'b0;
  logic hit_valid = 1'b0, trip_ready = 1'b1;
  logic hit_ready, trip_valid;
  logic [1:0] hit_plane = '0;
  logic [CW-1:0] hit_coord = '0;
  logic [CW-1:0] trip_a, trip_c, trip_b;

  int checks = 0, failures = 0;
  int exp_a [256], exp_c [256], got_a [256], got_c [256], got_b [256];
  int exp_n, got_n;
  bit first_v;

  always #10 clk = ~clk;

  tf_triplet_finder #(.CW(CW), .WIN(WIN)) dut (.*);

  typedef struct packed {
    logic [63:0] am;
    logic [63:0] cm;
    logic [5:0]  b;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{64'h400, 64'h4000,  6'd12, 8'd1},   // exact sum
    '{64'h400, 64'h8000,  6'd12, 8'd1},   // off by one
    '{64'h400, 64'h10000, 6'd12, 8'd0},   // off by two
    '{64'h1,   64'h3,     6'd0,  8'd2},   // low edge, two c
    '{64'h28,  64'hA0,    6'd5,  8'd2},   // two a, order
    '{64'h8000_0000_0000_0000, 64'hC000_0000_0000_0000, 6'd63, 8'd2},
    '{64'h1,   64'h8000_0000_0000_0000, 6'd31, 8'd1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic send_hit(input int pl, input int co);
    @(negedge clk);
    hit_valid = 1'b1; hit_plane = 2'(pl); hit_coord = CW'(co);
    while (!hit_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    #1 check(hit_ready == 1'b0, "R9", "hit_ready during clear", int'(hit_ready), 0);
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic fill(input logic [63:0] am, input logic [63:0] cm);
    for (int i = 0; i < N; i++) begin
      if (am[N-1-i]) send_hit(0, N-1-i);
      if (cm[i]) send_hit(2, i);
    end
  endtask

  task automatic model(input logic [63:0] am, input logic [63:0] cm, input int b);
    exp_n = 0;
    for (int a = 0; a < N; a++)
      for (int c = 0; c < N; c++)
        if (am[a] && cm[c] && (a + c - 2*b <= WIN) && (a + c - 2*b >= -WIN)) begin
          exp_a[exp_n] = a; exp_c[exp_n] = c; exp_n++;
        end
  endtask

  // called at the negedge right after a hit was accepted
  task automatic collect();
    got_n = 0;
    first_v = trip_valid;
    for (int i = 0; i < 400; i++) begin
      if (trip_valid) begin
        if (trip_ready) begin
          got_a[got_n] = trip_a; got_c[got_n] = trip_c; got_b[got_n] = trip_b;
          got_n++;
        end
      end else if (hit_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic run_centre(input logic [63:0] am, input logic [63:0] cm,
                            input int b, input string req);
    int bad;
    model(am, cm, b);
    send_hit(1, b);
    collect();
    check(got_n == exp_n, req, "triplet count", got_n, exp_n);
    if (exp_n > 0)
      check(first_v == 1'b1, "R8", "valid one cycle after accept", int'(first_v), 1);
    bad = 0;
    for (int i = 0; i < got_n && i < exp_n; i++)
      if (got_a[i] != exp_a[i] || got_c[i] != exp_c[i] || got_b[i] != b) bad++;
    check(bad == 0, "R5", "pairs/order mismatches", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] am, cm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(trip_valid == 1'b0, "R1", "trip_valid after reset", int'(trip_valid), 0);
    check(hit_ready == 1'b1, "R1", "hit_ready after reset", int'(hit_ready), 1);
    send_hit(1, 7);   // fill mode: ignored
    check(trip_valid == 1'b0, "R1", "no output in fill mode", int'(trip_valid), 0);
    do_start();
    run_centre(64'h0, 64'h0, 20, "R1");

    // table walk: R4 window, R5 order, R10 edges
    foreach (VT[t]) begin
      do_clear();
      fill(VT[t].am, VT[t].cm);
      do_start();
      run_centre(VT[t].am, VT[t].cm, int'(VT[t].b), (t >= 5) ? "R10" : "R4");
      check(got_n == int'(VT[t].n), "R4", "table count", got_n, int'(VT[t].n));
    end

    // R2: centre hit in fill mode ignored, pattern intact
    do_clear();
    fill(64'h400, 64'h4000);
    send_hit(1, 12);
    check(trip_valid == 1'b0, "R2", "centre hit in fill", int'(trip_valid), 0);
    @(negedge clk);
    check(trip_valid == 1'b0, "R2", "centre hit in fill +1", int'(trip_valid), 0);
    send_hit(3, 30);
    do_start();
    run_centre(64'h400, 64'h4000, 12, "R2");

    // R3: outer hits in match mode ignored
    send_hit(0, 11);
    send_hit(2, 13);
    run_centre(64'h400, 64'h4000, 12, "R3");

    // R6 / R7: consumer stall
    do_clear();
    fill(64'h28, 64'hA0);
    do_start();
    @(negedge clk); trip_ready = 1'b0;
    send_hit(1, 5);
    for (int i = 0; i < 4; i++) begin
      check(trip_valid && trip_a == 6'd3 && trip_c == 6'd7 && trip_b == 6'd5,
            "R6", "held triplet a", int'(trip_a), 3);
      check(hit_ready == 1'b0, "R7", "hit_ready while pending", int'(hit_ready), 1'b0);
      @(negedge clk);
    end
    trip_ready = 1'b1;
    collect();
    check(got_n == 2 && got_a[1] == 5 && got_c[1] == 5, "R6", "after stall count", got_n, 2);
    // R7: no-match centre hit, ready next cycle
    send_hit(1, 40);
    check(trip_valid == 1'b0 && hit_ready == 1'b1, "R7", "no-match ready", int'(hit_ready), 1);

    // R9: clear drops pending triplets
    trip_ready = 1'b0;
    send_hit(1, 5);
    check(trip_valid == 1'b1, "R9", "pending before clear", int'(trip_valid), 1);
    trip_ready = 1'b1;
    @(negedge clk); clear = 1'b1; trip_ready = 1'b0;
    @(negedge clk); clear = 1'b0;
    check(trip_valid == 1'b0, "R9", "valid after clear", int'(trip_valid), 0);
    trip_ready = 1'b1;

    // R9: clear beats start; arrays emptied
    @(negedge clk); clear = 1'b1; start = 1'b1;
    @(negedge clk); clear = 1'b0; start = 1'b0;
    send_hit(0, 20);
    send_hit(2, 20);
    send_hit(1, 20);
    check(trip_valid == 1'b0, "R9", "still fill mode after clear+start", int'(trip_valid), 0);
    do_start();
    run_centre(64'h0010_0000, 64'h0010_0000, 20, "R9");

    // random events against the brute-force model
    for (int ev = 0; ev < 20; ev++) begin
      am = '0; cm = '0;
      for (int j = 0; j < 9; j++) begin
        am[$urandom_range(N-1)] = 1'b1;
        cm[$urandom_range(N-1)] = 1'b1;
      end
      do_clear();
      fill(am, cm);
      do_start();
      for (int j = 0; j < 3; j++) run_centre(am, cm, int'($urandom_range(N-1)), "R4");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule